// File: doc/BRIEF.md
# Skip-Aware Next-PC Sequencer

This block holds the 15-bit program counter of a small 16-bit processor and picks the address of the next instruction. Each cycle the decoder presents an instruction class together with the Ra operand, the 15-bit jump immediate and a flag that tells whether the following word starts a two-word load-immediate. The block also receives the stack-underflow and stack-overflow requests from the register-window logic. When `step_en` is high the counter moves to the chosen address at the next clock edge.

The skip instructions jump over the next instruction. If that instruction is a load-immediate, the skip distance grows from 2 to 3 so that the immediate word is also passed over. A software trap saves the return address for R15 in the same cycle it takes effect. Software and stack traps share a three-entry vector space at the bottom of memory, and stack traps take precedence over all other sources. Every address computation wraps modulo 2^15.

Top module: `npc_sequencer`

## Requirements
- R1: While reset is active, and until the first enabled step after reset, `pc` is 0. Reset is asserted asynchronously and released synchronously, two clock edges after `rst_n` rises.
- R2: When `step_en` is low, `pc` keeps its value, and `trap_taken` and `r15_we` are 0, whatever the other inputs carry.
- R3: `op_class` encodes 0 sequential, 1 zero-skip, 2 negative-skip, 3 register jump, 4 absolute jump, 5 load-immediate, 6 software trap, 7 sequential. On an enabled step `pc` takes the value that `pc_next` showed before the edge. For classes 0 and 7, `pc_next` is `pc`+1 modulo 2^15.
- R4: For the zero-skip class (1), `pc_next` is `pc`+3 when `ra_val` is 0 and `next_is_ldim` is 1, and `pc`+2 when `ra_val` is 0 and `next_is_ldim` is 0. When `ra_val` is not 0 it is `pc`+1. All sums wrap modulo 2^15.
- R5: For the negative-skip class (2), the same 2-or-3 rule applies when bit 15 of `ra_val` is 1. Otherwise `pc_next` is `pc`+1.
- R6: For the load-immediate class (5), `pc_next` is `pc`+2 modulo 2^15.
- R7: For the register jump (3), `pc_next` is `ra_val[14:0]`. For the absolute jump (4), `pc_next` is `jmp_imm`.
- R8: For the software trap (6) with no stack request, `pc_next` is 1. On an enabled step, `r15_we` and `trap_taken` are 1 and `r15_wdata` is (`pc`+1 modulo 2^15) zero-extended to 16 bits.
- R9: When `stk_under` is 1, `pc_next` is 2 for any class. On an enabled step `trap_taken` is 1 and `r15_we` is 0.
- R10: When `stk_over` is 1 and `stk_under` is 0, `pc_next` is 3 for any class. On an enabled step `trap_taken` is 1 and `r15_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Instruction retires this cycle; PC advances |
| op_class | input | 3 | Decoded instruction class |
| ra_val | input | 16 | Ra operand value |
| jmp_imm | input | 15 | Absolute jump target |
| next_is_ldim | input | 1 | Following instruction is a load-immediate |
| stk_under | input | 1 | Stack underflow request |
| stk_over | input | 1 | Stack overflow request |
| pc | output | 15 | Current program counter |
| pc_next | output | 15 | Address selected for the next step |
| r15_we | output | 1 | Write return address into R15 |
| r15_wdata | output | 16 | Return address for R15 |
| trap_taken | output | 1 | A trap vector is taken this step |

## Verification
The block has only one piece of state, the PC register, so a wrong value there appears at the `pc` output in the cycle right after the faulty edge. It also skews every relative target on `pc_next` and the trap return address in that same cycle. Errors in target selection appear at `pc_next` before the edge and at `pc` one cycle later. After that the bench keeps following the design's own jumps, so each error keeps propagating. Priority mistakes between stack and software traps appear on `r15_we` and the vector value in the cycle the requests arrive.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [2:0] {
    OPC_SEQ  = 3'd0,
    OPC_SKZ  = 3'd1,
    OPC_SKN  = 3'd2,
    OPC_JR   = 3'd3,
    OPC_JMP  = 3'd4,
    OPC_LDIM = 3'd5,
    OPC_TRAP = 3'd6,
    OPC_RSVD = 3'd7
  } opc_e;

  localparam int unsigned OPC_W = 3;

endpackage

// File: rtl/npc_rst_sync.sv
module npc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/npc_flow.sv
module npc_flow
  import npc_pkg::*;
#(
  parameter int unsigned PC_W     = 15,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LDIM_LEN = 2
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [OPC_W-1:0]  op_class,
  input  logic [DATA_W-1:0] ra_val,
  input  logic [PC_W-1:0]   jmp_imm,
  input  logic              next_is_ldim,
  output logic [PC_W-1:0]   flow_pc,
  output logic              sw_trap
);

  localparam int unsigned DLT_W    = 2;
  localparam logic [DLT_W-1:0] DLT_ONE  = DLT_W'(1);
  localparam logic [DLT_W-1:0] DLT_SKIP = DLT_W'(2);
  localparam logic [DLT_W-1:0] DLT_LONG = DLT_W'(1 + LDIM_LEN);
  localparam logic [DLT_W-1:0] DLT_LDIM = DLT_W'(LDIM_LEN);

  opc_e             op;
  logic             ra_zero;
  logic             ra_neg;
  logic             skip_hit;
  logic [DLT_W-1:0] delta;
  logic [PC_W-1:0]  rel_pc;

  assign op      = opc_e'(op_class);
  assign ra_zero = (ra_val == '0);
  assign ra_neg  = ra_val[DATA_W-1];

  always_comb begin
    skip_hit = 1'b0;
    unique case (op)
      OPC_SKZ: skip_hit = ra_zero;
      OPC_SKN: skip_hit = ra_neg;
      default: skip_hit = 1'b0;
    endcase
  end

  always_comb begin
    delta = DLT_ONE;
    if (skip_hit) begin
      delta = next_is_ldim ? DLT_LONG : DLT_SKIP;
    end else if (op == OPC_LDIM) begin
      delta = DLT_LDIM;
    end
  end

  assign rel_pc = pc + PC_W'(delta);

  always_comb begin
    flow_pc = rel_pc;
    sw_trap = 1'b0;
    unique case (op)
      OPC_JR:   flow_pc = ra_val[PC_W-1:0];
      OPC_JMP:  flow_pc = jmp_imm;
      OPC_TRAP: sw_trap = 1'b1;
      default:  flow_pc = rel_pc;
    endcase
  end

endmodule

// File: rtl/npc_trap_arb.sv
module npc_trap_arb #(
  parameter int unsigned PC_W   = 15,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned VEC_SW = 1,
  parameter int unsigned VEC_UF = 2,
  parameter int unsigned VEC_OF = 3
) (
  input  logic              step_en,
  input  logic [PC_W-1:0]   pc,
  input  logic [PC_W-1:0]   flow_pc,
  input  logic              sw_trap,
  input  logic              stk_under,
  input  logic              stk_over,
  output logic [PC_W-1:0]   pc_next,
  output logic              trap_taken,
  output logic              r15_we,
  output logic [DATA_W-1:0] r15_wdata
);

  localparam logic [PC_W-1:0] V_SW = PC_W'(VEC_SW);
  localparam logic [PC_W-1:0] V_UF = PC_W'(VEC_UF);
  localparam logic [PC_W-1:0] V_OF = PC_W'(VEC_OF);
  localparam int unsigned     PAD_W = DATA_W - PC_W;

  logic            stk_any;
  logic [PC_W-1:0] ret_pc;

  assign stk_any = stk_under | stk_over;
  assign ret_pc  = pc + PC_W'(1);

  always_comb begin
    if (stk_under) begin
      pc_next = V_UF;
    end else if (stk_over) begin
      pc_next = V_OF;
    end else if (sw_trap) begin
      pc_next = V_SW;
    end else begin
      pc_next = flow_pc;
    end
  end

  assign trap_taken = step_en & (stk_any | sw_trap);
  assign r15_we     = step_en & sw_trap & ~stk_any;
  assign r15_wdata  = {{PAD_W{1'b0}}, ret_pc};

endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int unsigned PC_W     = 15,
  parameter int unsigned RESET_PC = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PC_W-1:0] d,
  output logic [PC_W-1:0] q
);

  logic [PC_W-1:0] pc_d;

  always_comb begin
    pc_d = q;
    if (en) begin
      pc_d = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= PC_W'(RESET_PC);
    end else begin
      q <= pc_d;
    end
  end

endmodule

// File: rtl/npc_sequencer.sv
module npc_sequencer
  import npc_pkg::*;
#(
  parameter int unsigned PC_W     = 15,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LDIM_LEN = 2,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [2:0]        op_class,
  input  logic [15:0]       ra_val,
  input  logic [14:0]       jmp_imm,
  input  logic              next_is_ldim,
  input  logic              stk_under,
  input  logic              stk_over,
  output logic [14:0]       pc,
  output logic [14:0]       pc_next,
  output logic              r15_we,
  output logic [15:0]       r15_wdata,
  output logic              trap_taken
);

  logic            rst_core_n;
  logic [PC_W-1:0] flow_pc;
  logic            sw_trap;

  npc_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  npc_flow #(.PC_W(PC_W), .DATA_W(DATA_W), .LDIM_LEN(LDIM_LEN)) u_flow (
    .pc           (pc),
    .op_class     (op_class),
    .ra_val       (ra_val),
    .jmp_imm      (jmp_imm),
    .next_is_ldim (next_is_ldim),
    .flow_pc      (flow_pc),
    .sw_trap      (sw_trap)
  );

  npc_trap_arb #(.PC_W(PC_W), .DATA_W(DATA_W)) u_arb (
    .step_en    (step_en),
    .pc         (pc),
    .flow_pc    (flow_pc),
    .sw_trap    (sw_trap),
    .stk_under  (stk_under),
    .stk_over   (stk_over),
    .pc_next    (pc_next),
    .trap_taken (trap_taken),
    .r15_we     (r15_we),
    .r15_wdata  (r15_wdata)
  );

  npc_pc_reg #(.PC_W(PC_W), .RESET_PC(0)) u_pc (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en    (step_en),
    .d     (pc_next),
    .q     (pc)
  );

endmodule

// File: rtl/npc_sequencer_chk.sv
module npc_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        step_en,
  input logic [2:0]  op_class,
  input logic [15:0] ra_val,
  input logic [14:0] jmp_imm,
  input logic        next_is_ldim,
  input logic        stk_under,
  input logic        stk_over,
  input logic [14:0] pc,
  input logic [14:0] pc_next,
  input logic        r15_we,
  input logic [15:0] r15_wdata,
  input logic        trap_taken
);

  logic no_stk;
  assign no_stk = !stk_under && !stk_over;

  a_r1_reset_pc: assert property (@(posedge clk) $rose(rst_n) |-> pc == 15'd0);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pc));

  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |-> !trap_taken && !r15_we);

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> pc == $past(pc_next));

  a_r4_skz_long: assert property (@(posedge clk) disable iff (!rst_n)
    no_stk && op_class == 3'd1 && ra_val == 16'd0 && next_is_ldim
    |-> pc_next == pc + 15'd3);

  a_r5_skn_short: assert property (@(posedge clk) disable iff (!rst_n)
    no_stk && op_class == 3'd2 && ra_val[15] && !next_is_ldim
    |-> pc_next == pc + 15'd2);

  a_r7_jumps: assert property (@(posedge clk) disable iff (!rst_n)
    no_stk && (op_class == 3'd3 || op_class == 3'd4)
    |-> pc_next == ((op_class == 3'd3) ? ra_val[14:0] : jmp_imm));

  a_r8_save: assert property (@(posedge clk) disable iff (!rst_n)
    r15_we |-> trap_taken && pc_next == 15'd1 &&
               r15_wdata == {1'b0, 15'(pc + 15'd1)});

  a_r9_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    stk_under |-> pc_next == 15'd2 && !r15_we);

  a_r10_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    stk_over && !stk_under |-> pc_next == 15'd3 && !r15_we);

endmodule

bind npc_sequencer npc_sequencer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .step_en      (step_en),
  .op_class     (op_class),
  .ra_val       (ra_val),
  .jmp_imm      (jmp_imm),
  .next_is_ldim (next_is_ldim),
  .stk_under    (stk_under),
  .stk_over     (stk_over),
  .pc           (pc),
  .pc_next      (pc_next),
  .r15_we       (r15_we),
  .r15_wdata    (r15_wdata),
  .trap_taken   (trap_taken)
);

// File: tb/npc_sequencer_bench.sv
module npc_sequencer_bench;

  localparam time CLK_HALF = 10ns;

  logic        clk;
  logic        rst_n;
  logic        step_en;
  logic [2:0]  op_class;
  logic [15:0] ra_val;
  logic [14:0] jmp_imm;
  logic        next_is_ldim;
  logic        stk_under;
  logic        stk_over;
  logic [14:0] pc;
  logic [14:0] pc_next;
  logic        r15_we;
  logic [15:0] r15_wdata;
  logic        trap_taken;

  int unsigned n_chk;
  int unsigned n_bad;
  logic [14:0] m_pc;
  bit          done;

  npc_sequencer u_npc_sequencer (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_en      (step_en),
    .op_class     (op_class),
    .ra_val       (ra_val),
    .jmp_imm      (jmp_imm),
    .next_is_ldim (next_is_ldim),
    .stk_under    (stk_under),
    .stk_over     (stk_over),
    .pc           (pc),
    .pc_next      (pc_next),
    .r15_we       (r15_we),
    .r15_wdata    (r15_wdata),
    .trap_taken   (trap_taken)
  );

  initial clk = 1'b0;
  always #(CLK_HALF) clk = ~clk;

  function automatic logic [14:0] model_next(logic [14:0] p, logic [2:0] op,
      logic [15:0] ra, logic [14:0] imm, logic ld, logic uf, logic ovf);
    logic [14:0] skipd;
    skipd = ld ? 15'd3 : 15'd2;
    if (uf)  return 15'd2;
    if (ovf) return 15'd3;
    case (op)
      3'd1:    return (ra == 16'd0) ? p + skipd : p + 15'd1;
      3'd2:    return ra[15] ? p + skipd : p + 15'd1;
      3'd3:    return ra[14:0];
      3'd4:    return imm;
      3'd5:    return p + 15'd2;
      3'd6:    return 15'd1;
      default: return p + 15'd1;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] op, logic uf, logic ovf);
    if (uf)  return "R9";
    if (ovf) return "R10";
    case (op)
      3'd1:       return "R4";
      3'd2:       return "R5";
      3'd3, 3'd4: return "R7";
      3'd5:       return "R6";
      3'd6:       return "R8";
      default:    return "R3";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic step(logic en, logic [2:0] op, logic [15:0] ra, logic [14:0] imm,
                      logic ld, logic uf, logic ovf);
    logic [14:0] exp_nx;
    string       t;
    @(negedge clk);
    step_en = en; op_class = op; ra_val = ra; jmp_imm = imm;
    next_is_ldim = ld; stk_under = uf; stk_over = ovf;
    #2ns;
    t = tag_of(op, uf, ovf);
    exp_nx = model_next(m_pc, op, ra, imm, ld, uf, ovf);
    check(t, "pc_next", 32'(pc_next), 32'(exp_nx));
    check(en ? t : "R2", "trap_taken", 32'(trap_taken),
          32'(en && (uf || ovf || op == 3'd6)));
    check(en ? t : "R2", "r15_we", 32'(r15_we),
          32'(en && op == 3'd6 && !uf && !ovf));
    if (en && op == 3'd6 && !uf && !ovf)
      check("R8", "r15_wdata", 32'(r15_wdata), {17'd0, 15'(m_pc + 15'd1)});
    @(posedge clk);
    #2ns;
    if (en) m_pc = exp_nx;
    check(en ? "R3" : "R2", "pc", 32'(pc), 32'(m_pc));
  endtask

  initial begin
    #(CLK_HALF * 2 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; step_en = 1'b0; op_class = 3'd0; ra_val = 16'd0;
    jmp_imm = 15'd0; next_is_ldim = 1'b0; stk_under = 1'b0; stk_over = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "pc in reset", 32'(pc), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_pc = 15'd0;
    check("R1", "pc after release", 32'(pc), 32'd0);

    step(1'b1, 3'd0, 16'h1234, 15'd0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 3'd1, 16'h0000, 15'd0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 3'd1, 16'h0000, 15'd0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 3'd1, 16'h0001, 15'd0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 3'd2, 16'h8000, 15'd0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 3'd2, 16'h7FFF, 15'd0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 3'd5, 16'h0000, 15'd0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 3'd3, 16'hFFFE, 15'd0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 3'd1, 16'h0000, 15'd0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 3'd4, 16'h0000, 15'h7FFF, 1'b0, 1'b0, 1'b0);
    step(1'b1, 3'd6, 16'h0000, 15'd0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 3'd4, 16'h0000, 15'h7FFF, 1'b0, 1'b0, 1'b0);
    step(1'b1, 3'd7, 16'h0000, 15'd0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 3'd6, 16'h0000, 15'd0, 1'b0, 1'b1, 1'b1);
    step(1'b1, 3'd6, 16'h0000, 15'd0, 1'b0, 1'b1, 1'b1);
    step(1'b1, 3'd6, 16'h0000, 15'd0, 1'b0, 1'b0, 1'b1);
    step(1'b1, 3'd4, 16'h0000, 15'h0100, 1'b0, 1'b1, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ra;
      int unsigned r;
      r  = $urandom();
      ra = 16'($urandom());
      if (r[1:0] == 2'd0) ra = 16'd0;
      step(r[4:2] != 3'd0, 3'(r[7:5]), ra, 15'($urandom()), r[8],
           r[11:9] == 3'd0, r[14:12] == 3'd0);
    end
    finish_run();
  end

endmodule